// File: doc/BRIEF.md
# Paged Bank Space Allocator

This block manages accelerator buffer space that lives inside the banks of a shared cache. Each bank keeps a short table of free contiguous extents, counted in minimum-page units. An allocation command gives a buffer size and a preference order of banks, nearest bank first. The block picks one page size for the whole buffer, so that no buffer needs more than a fixed number of pages. It then carves pages out of the extents and moves to the next bank only when the current bank cannot take another page. It reports each page placement on its output, one per cycle, and ends with a done pulse and a success flag.

A free command returns one page to its bank and joins it with any adjacent free extents. Each bank also has an occupancy ceiling, given in eighths of the bank. A caller that places several buffers as a group issues them largest first, and drops the group if any member fails. The block works on a private copy of the extent tables and writes that copy back only when the allocation succeeds. A failed allocation therefore leaves the free space as it was.

Top module: `pbank_alloc`

## Requirements
- R1: After reset `busy`, `pg_valid` and `done` are 0, and every bank holds one free extent covering all 16 of its units.
- R2: The page size is the smallest power of two, in units, whose product with NPAGE (32) is at least the request size, and it is never less than 1 unit. Every page has that size except the last, which holds the remainder.
- R3: A request of size 0 or larger than NPAGE*MAXP (256 units) ends with `done`=1 and `ok`=0 two cycles after the `alloc_go` cycle, and produces no pages.
- R4: Bank preference field i is `alloc_pref[2i+1:2i]` and names the i-th bank tried. Within a bank the first table slot whose extent is long enough is used, and the page is taken from the low end of that extent.
- R5: A bank's occupied units never exceed `cap_eighths`*16/8. A page that would break this limit moves the search on to the next preferred bank.
- R6: Each placed page shows for one cycle on `pg_valid` with `pg_bank`, `pg_base` and `pg_len`, at most one page per cycle. Every page lies inside its bank (base+len <= 16) and has a nonzero length.
- R7: `busy` is high from the cycle after an accepted `alloc_go` until `done`. `done` is a one-cycle pulse, and `ok`=1 only with `done` and only when every unit was placed.
- R8: A failed allocation leaves every extent table unchanged. Pages reported during a failed run are void.
- R9: A freed page is merged with the free extents that touch it on either side, so returning all pieces of a region restores a single extent.
- R10: A free issued in the same cycle as `alloc_go`, or while the allocation runs, is visible to that allocation and is kept even if the allocation fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_go | input | 1 | Start an allocation (taken only while not busy) |
| alloc_size | input | ZW (10) | Buffer size in minimum-page units |
| alloc_pref | input | NBANK*BW (8) | Bank order, field i = i-th bank tried |
| cap_eighths | input | 3 | Per-bank occupancy ceiling in eighths of a bank |
| free_go | input | 1 | Return one page |
| free_bank | input | BW (2) | Bank of the returned page |
| free_base | input | 4 | First unit of the returned page |
| free_len | input | 5 | Length of the returned page in units |
| busy | output | 1 | Allocation in progress |
| pg_valid | output | 1 | A page placement is shown this cycle |
| pg_bank | output | BW (2) | Bank of the placed page |
| pg_base | output | 4 | First unit of the placed page |
| pg_len | output | 5 | Length of the placed page in units |
| done | output | 1 | Allocation finished (one-cycle pulse) |
| ok | output | 1 | Allocation succeeded, valid with done |

## Verification
A free and the start of an allocation can land in the same cycle, and both touch the extent table of the same bank. The bench fills bank 1 up to its ceiling. It then raises `free_go` for the top unit of that bank in the same cycle as `alloc_go` for a one-unit buffer that prefers bank 1. The result is correct only if the single page lands back in bank 1 at the unit just freed. If the allocation had seen the table from before the free, the page would go to another bank. The same shared path is judged again by a failed allocation followed by a repeat request, whose first page shows that the rollback kept the earlier state.

// File: rtl/bap_pkg.sv
package bap_pkg;
  localparam int unsigned BANK_UNITS = 16;
  localparam int unsigned NSLOT      = 7;
  localparam int unsigned SW         = $clog2(BANK_UNITS);
  localparam int unsigned LW         = $clog2(BANK_UNITS + 1);
  localparam int unsigned IW         = $clog2(NSLOT);

  typedef logic [LW:0] wide_t;

  typedef struct packed {
    logic          vld;
    logic [SW-1:0] base;
    logic [LW-1:0] len;
  } ext_t;

  typedef ext_t [NSLOT-1:0] etab_t;

  typedef enum logic {ST_IDLE, ST_RUN} st_t;

  function automatic etab_t tab_init();
    etab_t t;
    t = '0;
    t[0].vld  = 1'b1;
    t[0].base = '0;
    t[0].len  = LW'(BANK_UNITS);
    return t;
  endfunction
endpackage

// File: rtl/bap_pgsize.sv
module bap_pgsize
  import bap_pkg::*;
#(
  parameter int unsigned NPAGE = 32,
  parameter int unsigned MAXP  = 8,
  parameter int unsigned ZW    = 10
) (
  input  logic [ZW-1:0] size_i,
  output logic [LW-1:0] unit_o,
  output logic          legal_o
);
  localparam int unsigned LGMAX = $clog2(MAXP);

  int unsigned u_v;

  always_comb begin
    u_v = 1;
    for (int k = 0; k < LGMAX; k++) begin
      if (u_v * NPAGE < int'(size_i)) u_v = u_v * 2;
    end
    unit_o  = LW'(u_v);
    legal_o = (size_i != '0) && (int'(size_i) <= NPAGE * MAXP);
  end
endmodule

// File: rtl/bap_merge.sv
module bap_merge
  import bap_pkg::*;
(
  input  etab_t         tab_i,
  input  logic          en_i,
  input  logic [SW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  output etab_t         tab_o
);
  logic          hit_l, hit_r, has_hole;
  logic [IW-1:0] li, ri, ki;

  always_comb begin
    hit_l = 1'b0; hit_r = 1'b0; has_hole = 1'b0;
    li = '0; ri = '0; ki = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!hit_l && tab_i[i].vld &&
          (wide_t'(tab_i[i].base) + wide_t'(tab_i[i].len) == wide_t'(base_i))) begin
        hit_l = 1'b1; li = IW'(i);
      end
      if (!hit_r && tab_i[i].vld &&
          (wide_t'(base_i) + wide_t'(len_i) == wide_t'(tab_i[i].base))) begin
        hit_r = 1'b1; ri = IW'(i);
      end
      if (!has_hole && !tab_i[i].vld) begin
        has_hole = 1'b1; ki = IW'(i);
      end
    end
    tab_o = tab_i;
    if (en_i) begin
      if (hit_l && hit_r) begin
        tab_o[li].len = tab_i[li].len + len_i + tab_i[ri].len;
        tab_o[ri]     = '0;
      end else if (hit_l) begin
        tab_o[li].len = tab_i[li].len + len_i;
      end else if (hit_r) begin
        tab_o[ri].base = base_i;
        tab_o[ri].len  = tab_i[ri].len + len_i;
      end else if (has_hole) begin
        tab_o[ki].vld  = 1'b1;
        tab_o[ki].base = base_i;
        tab_o[ki].len  = len_i;
      end
    end
  end
endmodule

// File: rtl/bap_carve.sv
module bap_carve
  import bap_pkg::*;
(
  input  etab_t         tab_i,
  input  logic [LW-1:0] need_i,
  input  logic [LW-1:0] limit_i,
  output logic          fit_o,
  output logic [SW-1:0] base_o,
  output etab_t         tab_o
);
  wide_t         free_sum, used;
  logic          hit, cap_ok;
  logic [IW-1:0] idx;

  always_comb begin
    free_sum = '0;
    hit      = 1'b0;
    idx      = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (tab_i[i].vld) free_sum = free_sum + wide_t'(tab_i[i].len);
      if (!hit && tab_i[i].vld && (tab_i[i].len >= need_i)) begin
        hit = 1'b1; idx = IW'(i);
      end
    end
    used   = wide_t'(BANK_UNITS) - free_sum;
    cap_ok = (used + wide_t'(need_i)) <= wide_t'(limit_i);
    fit_o  = hit && cap_ok && (need_i != '0);
    base_o = tab_i[idx].base;
    tab_o  = tab_i;
    if (fit_o) begin
      if (tab_i[idx].len == need_i) begin
        tab_o[idx] = '0;
      end else begin
        tab_o[idx].base = tab_i[idx].base + SW'(need_i);
        tab_o[idx].len  = tab_i[idx].len - need_i;
      end
    end
  end
endmodule

// File: rtl/pbank_alloc.sv
module pbank_alloc
  import bap_pkg::*;
#(
  parameter int unsigned NBANK = 4,
  parameter int unsigned NPAGE = 32,
  parameter int unsigned MAXP  = 8,
  localparam int unsigned BW   = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int unsigned ZW   = $clog2(NPAGE * MAXP + 1) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_go,
  input  logic [ZW-1:0]       alloc_size,
  input  logic [NBANK*BW-1:0] alloc_pref,
  input  logic [2:0]          cap_eighths,
  input  logic                free_go,
  input  logic [BW-1:0]       free_bank,
  input  logic [SW-1:0]       free_base,
  input  logic [LW-1:0]       free_len,
  output logic                busy,
  output logic                pg_valid,
  output logic [BW-1:0]       pg_bank,
  output logic [SW-1:0]       pg_base,
  output logic [LW-1:0]       pg_len,
  output logic                done,
  output logic                ok
);
  // reset: asserted at once, released through two flops
  logic [1:0] rsync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_q = rsync[1];

  st_t                 st, st_n;
  logic [BW-1:0]       pos, pos_n;
  logic [ZW-1:0]       rem, rem_n;
  logic [LW-1:0]       unit_q, lim_q;
  logic                bad_q;
  logic [NBANK*BW-1:0] pref_q;
  etab_t               live   [NBANK];
  etab_t               shad   [NBANK];
  etab_t               live_f [NBANK];
  etab_t               shad_c [NBANK];
  etab_t               shad_f [NBANK];
  etab_t               live_n [NBANK];
  etab_t               shad_n [NBANK];

  logic                ld, pv_n, done_n, ok_n;
  logic [LW-1:0]       unit_c, need, need_c, lim_c;
  logic                legal_c, fit;
  logic [SW-1:0]       cbase;
  etab_t               ctab;
  logic [BW-1:0]       cur_bank;

  assign busy     = (st == ST_RUN);
  assign ld       = (st == ST_IDLE) && alloc_go;
  assign cur_bank = pref_q[pos*BW +: BW];
  assign need     = (rem < ZW'(unit_q)) ? LW'(rem) : unit_q;
  assign need_c   = (busy && !bad_q) ? need : '0;
  assign lim_c    = LW'((int'(cap_eighths) * BANK_UNITS) / 8);

  bap_pgsize #(.NPAGE(NPAGE), .MAXP(MAXP), .ZW(ZW)) u_pgsize (
    .size_i(alloc_size), .unit_o(unit_c), .legal_o(legal_c)
  );

  bap_carve u_carve (
    .tab_i(shad[cur_bank]), .need_i(need_c), .limit_i(lim_q),
    .fit_o(fit), .base_o(cbase), .tab_o(ctab)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic fhit;
    assign fhit      = free_go && (free_bank == BW'(b));
    assign shad_c[b] = (fit && (cur_bank == BW'(b))) ? ctab : shad[b];

    bap_merge u_mlive (
      .tab_i(live[b]), .en_i(fhit), .base_i(free_base), .len_i(free_len),
      .tab_o(live_f[b])
    );
    bap_merge u_mshad (
      .tab_i(shad_c[b]), .en_i(fhit), .base_i(free_base), .len_i(free_len),
      .tab_o(shad_f[b])
    );
  end

  // next state
  always_comb begin
    st_n   = st;
    pos_n  = pos;
    rem_n  = rem;
    pv_n   = 1'b0;
    done_n = 1'b0;
    ok_n   = 1'b0;
    live_n = live_f;
    shad_n = shad_f;
    if (ld) begin
      st_n   = ST_RUN;
      pos_n  = '0;
      rem_n  = alloc_size;
      shad_n = live_f;
    end else if (busy) begin
      if (bad_q) begin
        done_n = 1'b1;
        st_n   = ST_IDLE;
      end else if (fit) begin
        pv_n  = 1'b1;
        rem_n = rem - ZW'(need);
        if (rem == ZW'(need)) begin
          done_n = 1'b1;
          ok_n   = 1'b1;
          st_n   = ST_IDLE;
          live_n = shad_f;
        end
      end else if (pos == BW'(NBANK - 1)) begin
        done_n = 1'b1;
        st_n   = ST_IDLE;
      end else begin
        pos_n = pos + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st       <= ST_IDLE;
      pos      <= '0;
      rem      <= '0;
      unit_q   <= '0;
      lim_q    <= '0;
      bad_q    <= 1'b0;
      pref_q   <= '0;
      pg_valid <= 1'b0;
      done     <= 1'b0;
      ok       <= 1'b0;
      pg_bank  <= '0;
      pg_base  <= '0;
      pg_len   <= '0;
      for (int b = 0; b < NBANK; b++) begin
        live[b] <= tab_init();
        shad[b] <= tab_init();
      end
    end else begin
      st       <= st_n;
      pos      <= pos_n;
      rem      <= rem_n;
      pg_valid <= pv_n;
      done     <= done_n;
      ok       <= ok_n;
      live     <= live_n;
      shad     <= shad_n;
      if (ld) begin
        unit_q <= unit_c;
        lim_q  <= lim_c;
        bad_q  <= !legal_c;
        pref_q <= alloc_pref;
      end
      if (pv_n) begin
        pg_bank <= cur_bank;
        pg_base <= cbase;
        pg_len  <= need;
      end
    end
  end
endmodule

// File: rtl/bap_chk.sv
module bap_chk
  import bap_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_go,
  input logic          busy,
  input logic          pg_valid,
  input logic [SW-1:0] pg_base,
  input logic [LW-1:0] pg_len,
  input logic          done,
  input logic          ok
);
  p_page_in_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pg_valid |-> ((pg_len != '0) &&
                  (wide_t'(pg_base) + wide_t'(pg_len) <= wide_t'(BANK_UNITS))));

  p_page_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pg_valid |-> $past(busy));

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_go && !busy) |=> busy);

  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ok_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> done);
endmodule

bind pbank_alloc bap_chk u_chk (
  .clk(clk), .rst_n(rst_q), .alloc_go(alloc_go), .busy(busy),
  .pg_valid(pg_valid), .pg_base(pg_base), .pg_len(pg_len),
  .done(done), .ok(ok)
);

// File: tb/test_pbank_alloc.sv
`timescale 1ns/1ps
module test_pbank_alloc;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       alloc_go;
  logic [9:0] alloc_size;
  logic [7:0] alloc_pref;
  logic [2:0] cap_eighths;
  logic       free_go;
  logic [1:0] free_bank;
  logic [3:0] free_base;
  logic [4:0] free_len;
  logic       busy, pg_valid, done, ok;
  logic [1:0] pg_bank;
  logic [3:0] pg_base;
  logic [4:0] pg_len;

  always #4 clk = ~clk;

  pbank_alloc i_pbank_alloc (
    .clk(clk), .rst_n(rst_n), .alloc_go(alloc_go), .alloc_size(alloc_size),
    .alloc_pref(alloc_pref), .cap_eighths(cap_eighths), .free_go(free_go),
    .free_bank(free_bank), .free_base(free_base), .free_len(free_len),
    .busy(busy), .pg_valid(pg_valid), .pg_bank(pg_bank), .pg_base(pg_base),
    .pg_len(pg_len), .done(done), .ok(ok)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit good, input string req, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // page code: bank*10000 + base*100 + len
  int got_ok, got_n, got_first, got_last, got_sum, got_odd, got_busy;
  int first_len;

  task automatic run_alloc(input int cap, input int size, input int pref,
                           input bit with_free, input int fb, input int fs, input int fl);
    int guard;
    bit fin;
    @(negedge clk);
    alloc_go = 1'b1; alloc_size = 10'(size); alloc_pref = 8'(pref);
    cap_eighths = 3'(cap);
    if (with_free) begin
      free_go = 1'b1; free_bank = 2'(fb); free_base = 4'(fs); free_len = 5'(fl);
    end
    @(negedge clk);
    alloc_go = 1'b0; free_go = 1'b0;
    got_busy = busy;
    got_n = 0; got_sum = 0; got_odd = 0; got_ok = 0;
    got_first = -1; got_last = -1; first_len = 0;
    fin = 1'b0; guard = 0;
    while (!fin && guard < 300) begin
      if (pg_valid) begin
        if (got_n == 0) begin
          got_first = pg_bank * 10000 + pg_base * 100 + pg_len;
          first_len = pg_len;
        end else if (got_last % 100 != first_len) begin
          got_odd++;
        end
        got_last = pg_bank * 10000 + pg_base * 100 + pg_len;
        got_sum += pg_len;
        got_n++;
      end
      if (done) begin
        got_ok = ok;
        fin = 1'b1;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    chk(fin, "R7 done reached", guard, 300);
    @(negedge clk);
  endtask

  task automatic free_one(input int b, input int s, input int l);
    @(negedge clk);
    free_go = 1'b1; free_bank = 2'(b); free_base = 4'(s); free_len = 5'(l);
    @(negedge clk);
    free_go = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0]  cap;
    logic [9:0]  size;
    logic [7:0]  pref;
    logic        ok;
    logic [5:0]  n;
    logic [16:0] first;
    logic [16:0] last;
  } vec_t;

  // pref 8'hE4 = order 0,1,2,3 ; 8'hE1 = order 1,0,2,3
  localparam vec_t VEC [4] = '{
    '{3'd4, 10'd5,  8'hE4, 1'b1, 6'd5, 17'd00001, 17'd00401},
    '{3'd4, 10'd6,  8'hE4, 1'b1, 6'd6, 17'd00501, 17'd10201},
    '{3'd4, 10'd40, 8'hE4, 1'b0, 6'd0, 17'd0,     17'd0},
    '{3'd4, 10'd5,  8'hE1, 1'b1, 6'd5, 17'd10301, 17'd10701}
  };

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; alloc_go = 1'b0; alloc_size = '0; alloc_pref = '0;
    cap_eighths = 3'd4; free_go = 1'b0; free_bank = '0; free_base = '0; free_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0,     "R1 busy after reset",  busy, 0);
    chk(pg_valid == 1'b0, "R1 pg_valid after reset", pg_valid, 0);
    chk(done == 1'b0,     "R1 done after reset",  done, 0);

    // table: R1 R4 R5 R8 (vector 0 starts at unit 0 of bank 0, vector 1 hits the cap,
    // vector 2 fails, vector 3 shows the failed run left bank 1 untouched)
    for (int i = 0; i < 4; i++) begin
      run_alloc(VEC[i].cap, VEC[i].size, VEC[i].pref, 1'b0, 0, 0, 0);
      chk(got_busy == 1, "R7 busy after go", got_busy, 1);
      chk(got_ok == int'(VEC[i].ok), $sformatf("R5 R8 vector %0d ok", i), got_ok, VEC[i].ok);
      if (VEC[i].ok) begin
        chk(got_n == int'(VEC[i].n), $sformatf("R4 vector %0d page count", i), got_n, VEC[i].n);
        chk(got_first == int'(VEC[i].first), $sformatf("R4 vector %0d first page", i),
            got_first, VEC[i].first);
        chk(got_last == int'(VEC[i].last), $sformatf("R5 R8 vector %0d last page", i),
            got_last, VEC[i].last);
      end
    end

    // R10: free of bank1 unit 7 in the same cycle as a 1-unit request for bank 1
    run_alloc(4, 1, 8'hE1, 1'b1, 1, 7, 1);
    chk(got_ok == 1, "R10 same-cycle free ok", got_ok, 1);
    chk(got_first == 10701, "R10 page reuses freed unit", got_first, 10701);

    // R9: return bank 0 units 0..7 one at a time, then a 14-unit request
    for (int u = 0; u < 8; u++) free_one(0, u, 1);
    run_alloc(7, 14, 8'hE4, 1'b0, 0, 0, 0);
    chk(got_ok == 1, "R9 merged alloc ok", got_ok, 1);
    chk(got_first == 1, "R9 merged extent used from unit 0", got_first, 1);
    chk(got_last == 1301, "R9 last page", got_last, 1301);

    // R3: illegal sizes
    run_alloc(4, 0, 8'hE4, 1'b0, 0, 0, 0);
    chk(got_ok == 0 && got_n == 0, "R3 size zero rejected", got_ok * 100 + got_n, 0);
    run_alloc(4, 300, 8'hE4, 1'b0, 0, 0, 0);
    chk(got_ok == 0 && got_n == 0, "R3 oversize rejected", got_ok * 100 + got_n, 0);

    // R2: 33 units -> 2-unit pages, last page of 1 unit; order 2,3,0,1 (8'h4E)
    run_alloc(7, 33, 8'h4E, 1'b0, 0, 0, 0);
    chk(got_ok == 1, "R2 ok", got_ok, 1);
    chk(got_n == 17, "R2 page count", got_n, 17);
    chk(got_first == 20002, "R2 first page", got_first, 20002);
    chk(got_last == 11201, "R2 short last page", got_last, 11201);
    chk(got_sum == 33, "R2 units placed", got_sum, 33);
    chk(got_odd == 0, "R2 equal pages before last", got_odd, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule